// File: doc/BRIEF.md
# Arithmetic Logic Unit with Packed Status Word

This block is a 16-bit arithmetic logic unit paired with a registered 16-bit flag word. Each cycle it takes two operands, an operation code and a byte/word select, and drives a combinational result. On the next rising clock edge, and only if the status write strobe is high, it stores the arithmetic status that the operation produces. The status is carry, parity, auxiliary carry, zero, sign and overflow. The word also holds three control bits: trap, interrupt-enable and direction. These are loaded only through a separate control write strobe. No arithmetic outcome ever touches them.

The flag register is the block's only state. It has three named transitions: RESET (all bits cleared), STATUS_LOAD (status bits named by the operation are replaced) and CONTROL_LOAD (the three control bits are replaced). When neither strobe is high it takes a fourth path, HOLD. STATUS_LOAD and CONTROL_LOAD can happen on the same edge, because they touch disjoint bits.

Operation codes: 0 add, 1 subtract, 2 AND, 3 OR, 4 increment, 5 decrement, 6 one's complement, 7 shift left by one, 8 logical shift right by one. Codes 9 to 15 are inert.

Top module: `alu_flags_core`

## Requirements
- R1: While reset is low, and in the cycle after its release, flags_o reads 16'h0000.
- R2: Add (code 0) and subtract (code 1) produce A+B and A-B within the selected width. Bit 0 of the flag word (carry) becomes the carry out of, or the borrow into, the top bit of that width.
- R3: AND (code 2) and OR (code 3) produce the bitwise result. They clear carry (bit 0), auxiliary carry (bit 4) and overflow (bit 11).
- R4: Increment (code 4) and decrement (code 5) produce A+1 and A-1 within the width, and leave carry (bit 0) unchanged.
- R5: For every flag-writing operation except complement, zero (bit 6) is set when the width-masked result is 0. Sign (bit 7) copies the result's top bit. Parity (bit 2) is set when result bits 7:0 hold an even number of ones.
- R6: Auxiliary carry (bit 4) is the carry out of bit 3 for add and increment, and the borrow into bit 3 for subtract and decrement. Shifts clear it.
- R7: Overflow (bit 11) is set on signed overflow of add, subtract, increment and decrement in the selected width.
- R8: Shift left puts the old top bit into carry, and overflow becomes carry XOR the new top bit. Logical shift right puts old bit 0 into carry and the old top bit into overflow.
- R9: With byte_i high, only bits 7:0 of the operands take part. result_o[15:8] reads 0, and carry, sign and overflow refer to bit 7.
- R10: Complement (code 6) drives ~A and changes no flag. Codes 9 to 15 drive A (width-masked) and change no flag.
- R11: With stat_we_i low, the six status bits keep their values while result_o still follows the inputs.
- R12: Control bits trap (bit 8), interrupt-enable (bit 9) and direction (bit 10) load from trap_i, intr_i and dir_i only on an edge with ctl_we_i high. Otherwise they hold.
- R13: Bits 1, 3, 5 and 15:12 of flags_o always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| byte_i | input | 1 | 1 = 8-bit operation, 0 = 16-bit |
| a_i | input | 16 | Operand A |
| b_i | input | 16 | Operand B |
| stat_we_i | input | 1 | Status bit write strobe |
| ctl_we_i | input | 1 | Control bit write strobe |
| trap_i | input | 1 | New trap bit value |
| intr_i | input | 1 | New interrupt-enable bit value |
| dir_i | input | 1 | New direction bit value |
| result_o | output | 16 | Combinational result |
| flags_o | output | 16 | Registered flag word |

## Verification
The result path holds no state, so a wrong datapath value shows on result_o in the same cycle the inputs are applied. A wrong status or control bit shows on flags_o one edge after the write strobe. Because the register holds its value, a corrupted bit then stays visible until the next write that targets it. The vectors are chained so that each operation that must preserve carry, and each non-writing operation, runs after one that left a known non-zero flag word. A bit that changes when it should not therefore shows as a mismatch on the very next comparison.

// File: rtl/alu_pkg.sv
package alu_pkg;

    // operation codes
    localparam logic [3:0] OP_ADD = 4'd0;
    localparam logic [3:0] OP_SUB = 4'd1;
    localparam logic [3:0] OP_AND = 4'd2;
    localparam logic [3:0] OP_OR  = 4'd3;
    localparam logic [3:0] OP_INC = 4'd4;
    localparam logic [3:0] OP_DEC = 4'd5;
    localparam logic [3:0] OP_NOT = 4'd6;
    localparam logic [3:0] OP_SHL = 4'd7;
    localparam logic [3:0] OP_SHR = 4'd8;

    // status vector indices (internal packing)
    localparam int ST_C = 0;
    localparam int ST_P = 1;
    localparam int ST_A = 2;
    localparam int ST_Z = 3;
    localparam int ST_S = 4;
    localparam int ST_O = 5;
    localparam int ST_N = 6;

    // control vector indices
    localparam int CT_T = 0;
    localparam int CT_I = 1;
    localparam int CT_D = 2;
    localparam int CT_N = 3;

    // flag word positions (fixed layout)
    localparam int FLAG_W = 16;
    localparam int FLG_C  = 0;
    localparam int FLG_P  = 2;
    localparam int FLG_A  = 4;
    localparam int FLG_Z  = 6;
    localparam int FLG_S  = 7;
    localparam int FLG_T  = 8;
    localparam int FLG_I  = 9;
    localparam int FLG_D  = 10;
    localparam int FLG_O  = 11;

    typedef logic [ST_N-1:0] stat_vec_t;
    typedef logic [CT_N-1:0] ctl_vec_t;

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic [DATA_W-1:0] x_i,
    input  logic [DATA_W-1:0] y_i,
    input  logic              inv_i,
    input  logic              byte_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              cf_o,
    output logic              af_o,
    output logic              of_o
);
    localparam int MSB_W = DATA_W - 1;
    localparam int MSB_B = BYTE_W - 1;
    localparam int NIB   = 4;

    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] x_m;
    logic [DATA_W-1:0] y_e;
    logic [DATA_W:0]   wide;
    logic              carry;
    logic              c_nib;
    logic              x_top;
    logic              y_top;
    logic              s_top;

    always_comb begin
        lane_mask = byte_i ? {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}} : {DATA_W{1'b1}};
        x_m       = x_i & lane_mask;
        y_e       = (y_i ^ {DATA_W{inv_i}}) & lane_mask;
        wide      = {1'b0, x_m} + {1'b0, y_e} + {{DATA_W{1'b0}}, inv_i};
        sum_o     = wide[DATA_W-1:0] & lane_mask;
        carry     = byte_i ? wide[BYTE_W] : wide[DATA_W];
        c_nib     = x_m[NIB] ^ y_e[NIB] ^ wide[NIB];
        x_top     = byte_i ? x_m[MSB_B] : x_m[MSB_W];
        y_top     = byte_i ? y_e[MSB_B] : y_e[MSB_W];
        s_top     = byte_i ? sum_o[MSB_B] : sum_o[MSB_W];
        // subtract forms A + ~B + 1; borrow is the inverted carry
        cf_o      = carry ^ inv_i;
        af_o      = c_nib ^ inv_i;
        of_o      = (x_top == y_top) && (s_top != x_top);
    end
endmodule

// File: rtl/alu_logic_shift.sv
module alu_logic_shift #(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic [3:0]        op_i,
    input  logic              byte_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cf_o,
    output logic              of_o
);
    import alu_pkg::*;

    localparam int MSB_W = DATA_W - 1;
    localparam int MSB_B = BYTE_W - 1;

    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] a_m;
    logic [DATA_W-1:0] b_m;
    logic              a_top;
    logic              r_top;

    always_comb begin
        lane_mask = byte_i ? {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}} : {DATA_W{1'b1}};
        a_m       = a_i & lane_mask;
        b_m       = b_i & lane_mask;
        a_top     = byte_i ? a_m[MSB_B] : a_m[MSB_W];
        res_o     = a_m;
        cf_o      = 1'b0;
        of_o      = 1'b0;
        unique case (op_i)
            OP_AND: res_o = a_m & b_m;
            OP_OR:  res_o = a_m | b_m;
            OP_NOT: res_o = ~a_m & lane_mask;
            OP_SHL: begin
                res_o = (a_m << 1) & lane_mask;
                cf_o  = a_top;
            end
            OP_SHR: begin
                res_o = a_m >> 1;
                cf_o  = a_m[0];
                of_o  = a_top;
            end
            default: res_o = a_m;
        endcase
        r_top = byte_i ? res_o[MSB_B] : res_o[MSB_W];
        if (op_i == OP_SHL) begin
            of_o = cf_o ^ r_top;
        end
    end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
    import alu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stat_we_i,
    input  stat_vec_t  upd_i,
    input  stat_vec_t  stat_d_i,
    input  logic       ctl_we_i,
    input  ctl_vec_t   ctl_d_i,
    output logic [FLAG_W-1:0] flags_o
);
    stat_vec_t stat_q;
    ctl_vec_t  ctl_q;

    // state register: status bits, one generated slice per bit
    for (genvar g = 0; g < ST_N; g++) begin : g_stat
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stat_q[g] <= 1'b0;
            end else if (stat_we_i && upd_i[g]) begin
                stat_q[g] <= stat_d_i[g];
            end
        end
    end

    // state register: control bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (ctl_we_i) begin
            ctl_q <= ctl_d_i;
        end
    end

    // outputs: pack into fixed word, unused positions zero
    always_comb begin
        flags_o        = '0;
        flags_o[FLG_C] = stat_q[ST_C];
        flags_o[FLG_P] = stat_q[ST_P];
        flags_o[FLG_A] = stat_q[ST_A];
        flags_o[FLG_Z] = stat_q[ST_Z];
        flags_o[FLG_S] = stat_q[ST_S];
        flags_o[FLG_O] = stat_q[ST_O];
        flags_o[FLG_T] = ctl_q[CT_T];
        flags_o[FLG_I] = ctl_q[CT_I];
        flags_o[FLG_D] = ctl_q[CT_D];
    end
endmodule

// File: rtl/alu_flags_core.sv
module alu_flags_core #(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic              byte_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              stat_we_i,
    input  logic              ctl_we_i,
    input  logic              trap_i,
    input  logic              intr_i,
    input  logic              dir_i,
    output logic [DATA_W-1:0] result_o,
    output logic [15:0]       flags_o
);
    import alu_pkg::*;

    localparam int MSB_W = DATA_W - 1;
    localparam int MSB_B = BYTE_W - 1;
    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    logic [DATA_W-1:0] add_y;
    logic              add_inv;
    logic [DATA_W-1:0] add_sum;
    logic              add_cf;
    logic              add_af;
    logic              add_of;
    logic [DATA_W-1:0] ls_res;
    logic              ls_cf;
    logic              ls_of;
    stat_vec_t         stat_d;
    stat_vec_t         upd;
    ctl_vec_t          ctl_d;
    logic              res_top;

    always_comb begin
        add_inv = (op_i == OP_SUB) || (op_i == OP_DEC);
        add_y   = ((op_i == OP_INC) || (op_i == OP_DEC)) ? ONE : b_i;
    end

    alu_adder #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_add (
        .x_i    (a_i),
        .y_i    (add_y),
        .inv_i  (add_inv),
        .byte_i (byte_i),
        .sum_o  (add_sum),
        .cf_o   (add_cf),
        .af_o   (add_af),
        .of_o   (add_of)
    );

    alu_logic_shift #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_ls (
        .op_i   (op_i),
        .byte_i (byte_i),
        .a_i    (a_i),
        .b_i    (b_i),
        .res_o  (ls_res),
        .cf_o   (ls_cf),
        .of_o   (ls_of)
    );

    always_comb begin
        stat_d = '0;
        upd    = '0;
        unique case (op_i)
            OP_ADD, OP_SUB: begin
                result_o     = add_sum;
                stat_d[ST_C] = add_cf;
                stat_d[ST_A] = add_af;
                stat_d[ST_O] = add_of;
                upd          = '1;
            end
            OP_INC, OP_DEC: begin
                result_o     = add_sum;
                stat_d[ST_A] = add_af;
                stat_d[ST_O] = add_of;
                upd          = '1;
                upd[ST_C]    = 1'b0;
            end
            OP_AND, OP_OR: begin
                result_o = ls_res;
                upd      = '1;
            end
            OP_SHL, OP_SHR: begin
                result_o     = ls_res;
                stat_d[ST_C] = ls_cf;
                stat_d[ST_O] = ls_of;
                upd          = '1;
            end
            default: begin
                result_o = ls_res;
            end
        endcase
        res_top      = byte_i ? result_o[MSB_B] : result_o[MSB_W];
        stat_d[ST_Z] = (result_o == '0);
        stat_d[ST_S] = res_top;
        stat_d[ST_P] = ~^result_o[BYTE_W-1:0];
        ctl_d[CT_T]  = trap_i;
        ctl_d[CT_I]  = intr_i;
        ctl_d[CT_D]  = dir_i;
    end

    alu_flag_reg u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_we_i (stat_we_i),
        .upd_i     (upd),
        .stat_d_i  (stat_d),
        .ctl_we_i  (ctl_we_i),
        .ctl_d_i   (ctl_d),
        .flags_o   (flags_o)
    );
endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        op_i,
    input logic              byte_i,
    input logic              stat_we_i,
    input logic              ctl_we_i,
    input logic              trap_i,
    input logic              intr_i,
    input logic              dir_i,
    input logic [DATA_W-1:0] result_o,
    input logic [15:0]       flags_o
);
    import alu_pkg::*;

    logic [5:0] stat_bits;
    assign stat_bits = {flags_o[FLG_O], flags_o[FLG_S], flags_o[FLG_Z],
                        flags_o[FLG_A], flags_o[FLG_P], flags_o[FLG_C]};

    // R11
    stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_we_i |=> $stable(stat_bits));

    // R12
    ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_we_i |=> $stable(flags_o[FLG_D:FLG_T]));

    // R12
    ctl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we_i |=> (flags_o[FLG_T] == $past(trap_i)) && (flags_o[FLG_I] == $past(intr_i))
                     && (flags_o[FLG_D] == $past(dir_i)));

    // R4
    incdec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_we_i && ((op_i == OP_INC) || (op_i == OP_DEC)) |=> $stable(flags_o[FLG_C]));

    // R3
    logic_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_we_i && ((op_i == OP_AND) || (op_i == OP_OR))
        |=> !flags_o[FLG_C] && !flags_o[FLG_A] && !flags_o[FLG_O]);

    // R10
    inert_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_NOT) || (op_i > OP_SHR) |=> $stable(stat_bits));

    // R5
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_we_i && (op_i <= OP_SHR) && (op_i != OP_NOT) && (result_o == '0)
        |=> flags_o[FLG_Z]);

    // R9
    byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_i |-> (result_o[DATA_W-1:8] == '0));

    // R13
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[15:12] == 4'h0) && !flags_o[1] && !flags_o[3] && !flags_o[5]);
endmodule

bind alu_flags_core alu_flags_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_i      (op_i),
    .byte_i    (byte_i),
    .stat_we_i (stat_we_i),
    .ctl_we_i  (ctl_we_i),
    .trap_i    (trap_i),
    .intr_i    (intr_i),
    .dir_i     (dir_i),
    .result_o  (result_o),
    .flags_o   (flags_o)
);

// File: tb/sim_alu_flags_core.sv
`timescale 1ns/1ps
module sim_alu_flags_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = '0;
    logic        byte_i = 1'b0;
    logic [15:0] a_i = '0;
    logic [15:0] b_i = '0;
    logic        stat_we_i = 1'b0;
    logic        ctl_we_i = 1'b0;
    logic        trap_i = 1'b0;
    logic        intr_i = 1'b0;
    logic        dir_i = 1'b0;
    logic [15:0] result_o;
    logic [15:0] flags_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit all_sent = 0;

    typedef struct {
        logic [15:0] res;
        logic [15:0] flg;
        string       tag;
    } item_t;

    item_t       sb[$];
    logic [15:0] exp_flags = '0;

    always #4 clk = ~clk;

    alu_flags_core u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .byte_i(byte_i), .a_i(a_i), .b_i(b_i),
        .stat_we_i(stat_we_i), .ctl_we_i(ctl_we_i), .trap_i(trap_i), .intr_i(intr_i),
        .dir_i(dir_i), .result_o(result_o), .flags_o(flags_o)
    );

    // independent reference built from the requirement text
    function automatic item_t model(input logic [3:0] op, input logic bm,
                                    input logic [15:0] a, input logic [15:0] b,
                                    input logic swe, input logic cwe,
                                    input logic t, input logic i, input logic d,
                                    input logic [15:0] fin);
        item_t       it;
        logic [16:0] mask, am, bb, full;
        logic [15:0] r;
        logic        cf, pf, af, zf, sf, of, wr, pzs;
        int          hi;
        mask = bm ? 17'h000FF : 17'h0FFFF;
        hi   = bm ? 7 : 15;
        am   = {1'b0, a} & mask;
        bb   = {1'b0, b} & mask;
        cf = fin[0]; pf = fin[2]; af = fin[4]; zf = fin[6]; sf = fin[7]; of = fin[11];
        wr = 1'b1; pzs = 1'b1;
        case (op)
            4'd0: begin
                full = am + bb; r = full[15:0] & mask[15:0];
                cf = bm ? full[8] : full[16];
                af = ({1'b0, am[3:0]} + {1'b0, bb[3:0]}) > 5'd15;
                of = (am[hi] == bb[hi]) && (r[hi] != am[hi]);
            end
            4'd1: begin
                full = (am - bb) & mask; r = full[15:0];
                cf = am < bb; af = am[3:0] < bb[3:0];
                of = (am[hi] != bb[hi]) && (r[hi] != am[hi]);
            end
            4'd2: begin r = am[15:0] & bb[15:0]; cf = 0; of = 0; af = 0; end
            4'd3: begin r = am[15:0] | bb[15:0]; cf = 0; of = 0; af = 0; end
            4'd4: begin
                full = (am + 17'd1) & mask; r = full[15:0];
                af = am[3:0] == 4'hF; of = r[hi] && !am[hi];
            end
            4'd5: begin
                full = (am - 17'd1) & mask; r = full[15:0];
                af = am[3:0] == 4'h0; of = !r[hi] && am[hi];
            end
            4'd6: begin r = ~am[15:0] & mask[15:0]; wr = 0; pzs = 0; end
            4'd7: begin
                full = (am << 1) & mask; r = full[15:0];
                cf = am[hi]; of = cf ^ r[hi]; af = 0;
            end
            4'd8: begin r = am[16:1]; cf = am[0]; of = am[hi]; af = 0; end
            default: begin r = am[15:0]; wr = 0; pzs = 0; end
        endcase
        it.flg = fin;
        if (swe && wr) begin
            if (pzs) begin
                zf = (r == 16'h0); sf = r[hi]; pf = ~^r[7:0];
            end
            it.flg[0] = cf; it.flg[2] = pf; it.flg[4] = af;
            it.flg[6] = zf; it.flg[7] = sf; it.flg[11] = of;
        end
        if (cwe) begin
            it.flg[8] = t; it.flg[9] = i; it.flg[10] = d;
        end
        it.res = r;
        return it;
    endfunction

    // driver: one operation per cycle, expected item queued
    task automatic drive(input logic [3:0] op, input logic bm, input logic [15:0] a,
                         input logic [15:0] b, input logic swe, input logic cwe,
                         input logic t, input logic i, input logic d, input string tag);
        item_t it;
        @(negedge clk);
        op_i = op; byte_i = bm; a_i = a; b_i = b;
        stat_we_i = swe; ctl_we_i = cwe; trap_i = t; intr_i = i; dir_i = d;
        it = model(op, bm, a, b, swe, cwe, t, i, d, exp_flags);
        it.tag = tag;
        exp_flags = it.flg;
        sb.push_back(it);
    endtask

    task automatic check16(input string tag, input string what,
                           input logic [15:0] got, input logic [15:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
        end
    endtask

    // monitor: result sampled before the edge, flags after it
    initial begin
        forever begin
            @(posedge clk);
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                check16(it.tag, "result", result_o, it.res);
                #2;
                check16(it.tag, "flags", flags_o, it.flg);
            end
        end
    end

    initial begin
        #(200000 * 8);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired got running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check16("R1 in reset", "flags", flags_o, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check16("R1 after release", "flags", flags_o, 16'h0000);

        // R2 add/sub carry and borrow
        drive(4'd0, 0, 16'hFFFF, 16'h0001, 1, 0, 0, 0, 0, "R2 add word carry");
        drive(4'd1, 0, 16'h0003, 16'h0005, 1, 0, 0, 0, 0, "R2 sub word borrow");
        // R7 overflow
        drive(4'd0, 0, 16'h7FFF, 16'h0001, 1, 0, 0, 0, 0, "R7 add word overflow");
        drive(4'd1, 1, 16'hAA80, 16'h5501, 1, 0, 0, 0, 0, "R7 sub byte overflow");
        // R9 byte mode
        drive(4'd0, 1, 16'h12FF, 16'h3401, 1, 0, 0, 0, 0, "R9 add byte carry");
        // R6 auxiliary carry
        drive(4'd0, 0, 16'h0008, 16'h0008, 1, 0, 0, 0, 0, "R6 add nibble carry");
        drive(4'd1, 0, 16'h0010, 16'h0001, 1, 0, 0, 0, 0, "R6 sub nibble borrow");
        // R5 parity and sign
        drive(4'd0, 0, 16'h0100, 16'h0003, 1, 0, 0, 0, 0, "R5 parity even");
        drive(4'd0, 0, 16'h8100, 16'h0007, 1, 0, 0, 0, 0, "R5 parity odd sign");
        // carry set before logic ops, then cleared
        drive(4'd1, 0, 16'h0000, 16'h0001, 1, 0, 0, 0, 0, "R2 set carry");
        drive(4'd2, 0, 16'hF0F0, 16'h3C3C, 1, 0, 0, 0, 0, "R3 and word");
        drive(4'd1, 0, 16'h0000, 16'h0001, 1, 0, 0, 0, 0, "R2 set carry again");
        drive(4'd3, 1, 16'hFF00, 16'h0081, 1, 0, 0, 0, 0, "R3 or byte");
        // R4 carry preserved
        drive(4'd1, 0, 16'h0000, 16'h0001, 1, 0, 0, 0, 0, "R4 preset carry");
        drive(4'd4, 0, 16'hFFFF, 16'h0000, 1, 0, 0, 0, 0, "R4 inc word wrap");
        drive(4'd4, 1, 16'h007F, 16'h0000, 1, 0, 0, 0, 0, "R4 inc byte overflow");
        drive(4'd5, 0, 16'h0000, 16'h0000, 1, 0, 0, 0, 0, "R4 dec word wrap");
        drive(4'd5, 0, 16'h8000, 16'h0000, 1, 0, 0, 0, 0, "R7 dec word overflow");
        // R10 inert operations
        drive(4'd6, 0, 16'h1234, 16'h0000, 1, 0, 0, 0, 0, "R10 complement word");
        drive(4'd6, 1, 16'hAB0F, 16'h0000, 1, 0, 0, 0, 0, "R10 complement byte");
        drive(4'd12, 0, 16'h5A5A, 16'hFFFF, 1, 0, 0, 0, 0, "R10 inert code");
        // R8 shifts
        drive(4'd7, 0, 16'h8001, 16'h0000, 1, 0, 0, 0, 0, "R8 shl word");
        drive(4'd7, 1, 16'h0040, 16'h0000, 1, 0, 0, 0, 0, "R8 shl byte");
        drive(4'd8, 0, 16'h0003, 16'h0000, 1, 0, 0, 0, 0, "R8 shr word");
        drive(4'd8, 1, 16'hFF81, 16'h0000, 1, 0, 0, 0, 0, "R8 shr byte");
        // R11 write disabled
        drive(4'd0, 0, 16'h0000, 16'h0000, 0, 0, 0, 0, 0, "R11 hold on zero sum");
        drive(4'd1, 0, 16'h0001, 16'h0002, 0, 0, 0, 0, 0, "R11 hold on borrow");
        // R12 control bits
        drive(4'd0, 0, 16'h0001, 16'h0001, 0, 1, 1, 0, 1, "R12 control load");
        drive(4'd0, 0, 16'hFFFF, 16'h0001, 1, 0, 0, 1, 0, "R12 status keeps control");
        drive(4'd12, 0, 16'h0000, 16'h0000, 0, 1, 0, 1, 1, "R12 control reload");
        // R13 all flag bits busy, reserved stay zero
        drive(4'd1, 0, 16'h8000, 16'h0001, 1, 1, 1, 1, 1, "R13 layout full");

        @(negedge clk);
        stat_we_i = 0; ctl_we_i = 0;
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule